// File: doc/BRIEF.md
# Synchronous Serial Master Shifter

This block is the bus-master end of a four-wire synchronous serial link. A word offered on the parallel side with a valid/ready handshake is shifted out most significant bit first on the data-out line while the block samples the data-in line. At the end of each frame the received word is returned together with a one-cycle valid strobe. The block drives the serial clock and an active-low frame select.

Configuration is taken from plain inputs and latched when a frame starts: word length (4 to 16 bits), clock idle level, capture phase, an even prescale value, an 8-bit rate value, internal loopback and enable. One serial bit lasts prescale × (rate + 1) system clock cycles, so each half bit lasts half that. Dropping enable stops a frame at once and returns the link to idle.

Top module: `sser_master`

## Requirements
- R1: `cfg_len_m1` holds the word length minus one. A frame carries N = `cfg_len_m1`+1 bits and makes 2N serial clock transitions. Codes 0, 1 and 2 are treated as 3, which gives N = 4.
- R2: Let Peff be `cfg_prescale` with bit 0 cleared, raised to 2 if that gives 0. A half-bit period is H = (Peff/2)·(`cfg_rate`+1) system clock cycles. The first transition comes H cycles after the accepting edge, and each later transition comes H cycles after the one before.
- R3: Bit 0 of `cfg_prescale` has no effect. Prescale values 0 and 1 both behave as 2.
- R4: While no frame runs, `sclk` equals the `cfg_cpol` value sampled at the previous clock edge. Polarity 1 means the clock idles high.
- R5: With `cfg_cpha`=0, transitions 1, 3, 5, … of a frame capture data in and the other transitions move data out. With `cfg_cpha`=1, the even-numbered transitions (2, 4, …) capture data in.
- R6: Data out carries the low N bits of `tx_data`, most significant first. The first bit is valid from the edge where `ss_n` falls.
- R7: With `cfg_loopback`=1, the data-out stream is captured in place of `miso`, so `rx_data` equals the low N bits of the transmitted word whatever `miso` does.
- R8: `rx_valid` is high for exactly one cycle. It rises on the same edge on which `ss_n` rises, H cycles after the last transition. Bits N and above of `rx_data` are then zero.
- R9: `tx_ready` = `cfg_enable` and not `busy`. A word is accepted on an edge where `tx_valid` and `tx_ready` are both high. From that edge `busy` is 1 and `ss_n` is 0 until the frame ends, and `ss_n` is always the inverse of `busy`.
- R10: While `cfg_enable` is 0, each edge ends any frame: `ss_n`=1, `busy`=0, `sclk` follows `cfg_cpol`, and no `rx_valid` is produced. This also holds on the edge on which the frame would otherwise have completed.
- R11: After reset, `ss_n`=1, `sclk`=0, `busy`=0, `rx_valid`=0, `rx_data`=0 and `mosi`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Engine enable; low aborts a frame |
| cfg_len_m1 | input | 4 | Word length minus one |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Capture on second transition when 1 |
| cfg_prescale | input | 8 | Even prescale value (bit 0 ignored) |
| cfg_rate | input | 8 | Rate value; divides by value plus one |
| cfg_loopback | input | 1 | Capture own data out instead of miso |
| tx_data | input | 16 | Word to send, right aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine can accept a word |
| rx_data | output | 16 | Last received word, right aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | Frame in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low frame select |

## Verification
Two events can land on the same edge: the half-bit tick that closes a frame and an enable drop that aborts it. The bench takes the accepting edge and works out H·(2N+1) from the configuration. It then removes enable exactly one cycle before that closing edge. It first confirms the frame is still open, then expects `ss_n` high, `busy` low and no `rx_valid` strobe, since the abort must win. A related collision is a held `tx_valid` that restarts a frame on the edge right after `rx_valid`. That case is judged by `busy` rising one cycle later and by the second word returning intact.

// File: rtl/sser_pkg.sv
package sser_pkg;

  // smallest legal length code (length minus one)
  localparam int MIN_LEN_M1 = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sser_state_e;

endpackage

// File: rtl/sser_rate.sv
// Half-bit tick generator: a prescale stage of Peff/2 cycles cascaded
// with a rate stage of (rate+1) wraps.
module sser_rate #(
  parameter int PSW = 8,
  parameter int RW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic [PSW-1:0] prescale,
  input  logic [RW-1:0]  rate,
  output logic           tick
);

  localparam int HPW = PSW - 1;

  logic [HPW-1:0] half_pre;
  logic [HPW-1:0] pcnt_q;
  logic [RW-1:0]  rcnt_q;
  logic           pre_end;

  // bit 0 dropped; zero becomes one (prescale of two)
  assign half_pre = (prescale[PSW-1:1] == '0) ? HPW'(1) : prescale[PSW-1:1];
  assign pre_end  = (pcnt_q == half_pre - HPW'(1));
  assign tick     = run && pre_end && (rcnt_q == rate);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt_q <= '0;
      rcnt_q <= '0;
    end else if (pre_end) begin
      pcnt_q <= '0;
      if (rcnt_q == rate) rcnt_q <= '0;
      else                rcnt_q <= rcnt_q + RW'(1);
    end else begin
      pcnt_q <= pcnt_q + HPW'(1);
    end
  end

endmodule

// File: rtl/sser_shift.sv
// Transmit and receive shift registers. The transmit word is left aligned
// so the serial output is always the top bit.
module sser_shift #(
  parameter int DW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [DW-1:0]         word,
  input  logic [$clog2(DW)-1:0] len_m1,
  input  logic                  shift_en,
  input  logic                  sample_en,
  input  logic                  din,
  output logic                  dout,
  output logic [DW-1:0]         rx_word
);

  localparam int LENW = $clog2(DW);

  logic [DW-1:0]   txsr_q;
  logic [DW-1:0]   rxsr_q;
  logic [LENW-1:0] align;

  assign align   = LENW'(DW - 1) - len_m1;
  assign dout    = txsr_q[DW-1];
  assign rx_word = rxsr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      txsr_q <= '0;
    end else if (load) begin
      txsr_q <= word << align;
    end else if (shift_en) begin
      txsr_q <= {txsr_q[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxsr_q <= '0;
    end else if (load) begin
      rxsr_q <= '0;
    end else if (sample_en) begin
      rxsr_q <= {rxsr_q[DW-2:0], din};
    end
  end

endmodule

// File: rtl/sser_master.sv
module sser_master #(
  parameter int DW  = 16,
  parameter int PSW = 8,
  parameter int RW  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_enable,
  input  logic [$clog2(DW)-1:0] cfg_len_m1,
  input  logic                  cfg_cpol,
  input  logic                  cfg_cpha,
  input  logic [PSW-1:0]        cfg_prescale,
  input  logic [RW-1:0]         cfg_rate,
  input  logic                  cfg_loopback,
  input  logic [DW-1:0]         tx_data,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  output logic [DW-1:0]         rx_data,
  output logic                  rx_valid,
  output logic                  busy,
  output logic                  sclk,
  output logic                  mosi,
  input  logic                  miso,
  output logic                  ss_n
);

  import sser_pkg::*;

  localparam int LENW = $clog2(DW);
  localparam int ECW  = $clog2(2 * DW + 1);

  sser_state_e     state_q;
  logic [ECW-1:0]  ecnt_q;
  logic [LENW-1:0] len_q;
  logic            cpha_q, cpol_q, loop_q;
  logic [PSW-1:0]  pre_q;
  logic [RW-1:0]   rate_q;
  logic            sclk_q, ssn_q, rxv_q;
  logic [DW-1:0]   rxd_q;

  logic            tick, run, start;
  logic [LENW-1:0] len_eff;
  logic [ECW-1:0]  edges_total;
  logic            at_end, edge_go, sample_en, shift_en;
  logic            din, dout;
  logic [DW-1:0]   rx_word;

  assign run     = (state_q == ST_RUN);
  assign start   = (state_q == ST_IDLE) && cfg_enable && tx_valid;
  assign len_eff = (cfg_len_m1 < LENW'(MIN_LEN_M1)) ? LENW'(MIN_LEN_M1) : cfg_len_m1;

  // 2N transitions per frame; the tick after the last one closes it
  assign edges_total = ECW'({len_q, 1'b0}) + ECW'(2);
  assign at_end      = tick && (ecnt_q == edges_total);
  assign edge_go     = tick && !at_end;
  assign sample_en   = edge_go && (ecnt_q[0] == cpha_q);
  assign shift_en    = edge_go && (cpha_q ? (!ecnt_q[0] && (ecnt_q != '0)) : ecnt_q[0]);
  assign din         = loop_q ? dout : miso;

  sser_rate #(.PSW(PSW), .RW(RW)) u_rate (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .prescale (pre_q),
    .rate     (rate_q),
    .tick     (tick)
  );

  sser_shift #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .word      (tx_data),
    .len_m1    (len_eff),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .din       (din),
    .dout      (dout),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ecnt_q  <= '0;
      len_q   <= LENW'(MIN_LEN_M1);
      cpha_q  <= 1'b0;
      cpol_q  <= 1'b0;
      loop_q  <= 1'b0;
      pre_q   <= '0;
      rate_q  <= '0;
      sclk_q  <= 1'b0;
      ssn_q   <= 1'b1;
      rxv_q   <= 1'b0;
      rxd_q   <= '0;
    end else begin
      rxv_q <= 1'b0;
      if (!cfg_enable) begin
        state_q <= ST_IDLE;
        ssn_q   <= 1'b1;
        sclk_q  <= cfg_cpol;
        ecnt_q  <= '0;
      end else if (state_q == ST_IDLE) begin
        sclk_q <= cfg_cpol;
        if (tx_valid) begin
          state_q <= ST_RUN;
          ssn_q   <= 1'b0;
          ecnt_q  <= '0;
          len_q   <= len_eff;
          cpha_q  <= cfg_cpha;
          cpol_q  <= cfg_cpol;
          loop_q  <= cfg_loopback;
          pre_q   <= cfg_prescale;
          rate_q  <= cfg_rate;
        end
      end else if (tick) begin
        if (at_end) begin
          state_q <= ST_IDLE;
          ssn_q   <= 1'b1;
          rxv_q   <= 1'b1;
          rxd_q   <= rx_word;
          sclk_q  <= cpol_q;
        end else begin
          sclk_q <= ~sclk_q;
          ecnt_q <= ecnt_q + ECW'(1);
        end
      end
    end
  end

  assign tx_ready = (state_q == ST_IDLE) && cfg_enable;
  assign busy     = run;
  assign sclk     = sclk_q;
  assign mosi     = dout;
  assign ss_n     = ssn_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;

endmodule

// File: rtl/sser_master_chk.sv
module sser_master_chk #(
  parameter int DW = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_enable,
  input logic [$clog2(DW)-1:0] cfg_len_m1,
  input logic                  cfg_cpol,
  input logic                  tx_valid,
  input logic                  tx_ready,
  input logic                  busy,
  input logic                  sclk,
  input logic                  ss_n,
  input logic                  rx_valid,
  input logic [DW-1:0]         rx_data
);

  localparam int NW = $clog2(DW) + 2;

  logic [NW-1:0] nbits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nbits_q <= NW'(DW);
    end else if (tx_valid && tx_ready) begin
      nbits_q <= (cfg_len_m1 < 3) ? NW'(4) : NW'(cfg_len_m1) + NW'(1);
    end
  end

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !busy);

  // R9
  sel_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ss_n);

  // R9
  sel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ss_n);

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> (busy && !ss_n));

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> (ss_n && !busy && !rx_valid));

  // R8
  rxv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8
  rxv_close_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $rose(ss_n));

  // R8
  rx_upper_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> nbits_q) == '0));

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $past(!rst)) |-> (sclk == $past(cfg_cpol)));

endmodule

bind sser_master sser_master_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_enable (cfg_enable),
  .cfg_len_m1 (cfg_len_m1),
  .cfg_cpol   (cfg_cpol),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .busy       (busy),
  .sclk       (sclk),
  .ss_n       (ss_n),
  .rx_valid   (rx_valid),
  .rx_data    (rx_data)
);

// File: tb/sim_sser_master.sv
module sim_sser_master;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic [3:0]  cfg_len_m1 = 4'd7;
  logic        cfg_cpol = 1'b0;
  logic        cfg_cpha = 1'b0;
  logic [7:0]  cfg_prescale = 8'd2;
  logic [7:0]  cfg_rate = 8'd0;
  logic        cfg_loopback = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        miso = 1'b0;
  logic        tx_ready, rx_valid, busy, sclk, mosi, ss_n;
  logic [15:0] rx_data;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #(CLK_P/2) clk = ~clk;

  sser_master u0 (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_len_m1(cfg_len_m1),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_prescale(cfg_prescale),
    .cfg_rate(cfg_rate), .cfg_loopback(cfg_loopback), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .busy(busy), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ss_n(ss_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #(CLK_P/4);
  endtask

  function automatic int half_of(input int pre, input int rate);
    int p;
    p = pre;
    if (p % 2 == 1) p = p - 1;
    if (p < 2) p = 2;
    return (p / 2) * (rate + 1);
  endfunction

  function automatic int len_of(input int code);
    return (code < 3) ? 4 : code + 1;
  endfunction

  // ---------------- cycle reference model ----------------
  bit m_live = 0;
  bit m_run = 0, m_sclk = 0, m_ssn = 1, m_rxv = 0, m_cpol = 0;
  int m_cnt = 0, m_edge = 0, m_h = 1, m_n = 4;

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_sclk = 0; m_ssn = 1; m_rxv = 0;
    end else begin
      m_rxv = 0;
      if (!cfg_enable) begin
        m_run = 0; m_ssn = 1; m_sclk = cfg_cpol;
      end else if (!m_run) begin
        m_sclk = cfg_cpol;
        if (tx_valid) begin
          m_run = 1; m_ssn = 0; m_cnt = 0; m_edge = 0; m_cpol = cfg_cpol;
          m_n = len_of(int'(cfg_len_m1));
          m_h = half_of(int'(cfg_prescale), int'(cfg_rate));
        end
      end else begin
        m_cnt++;
        if (m_cnt == m_h) begin
          m_cnt = 0;
          if (m_edge == 2 * m_n) begin
            m_run = 0; m_ssn = 1; m_rxv = 1; m_sclk = m_cpol;
          end else begin
            m_sclk = !m_sclk; m_edge++;
          end
        end
      end
    end
    m_live = 1;
  end

  always @(negedge clk) begin
    if (m_live && !rst) begin
      chk(sclk == m_sclk, "R2", "sclk", int'(sclk), int'(m_sclk));
      chk(ss_n == m_ssn, "R9", "ss_n", int'(ss_n), int'(m_ssn));
      chk(busy == m_run, "R9", "busy", int'(busy), int'(m_run));
      chk(rx_valid == m_rxv, "R8", "rx_valid", int'(rx_valid), int'(m_rxv));
      chk(tx_ready == (!m_run && cfg_enable), "R9", "tx_ready",
          int'(tx_ready), int'(!m_run && cfg_enable));
    end
  end

  // ---------------- bench slave ----------------
  int   b_n = 8;
  bit   b_cpha = 0, b_lb = 0;
  logic [15:0] b_slv = '0;
  int   trans = 0;
  int   cap = 0;
  logic p_ssn = 1'b1, p_sclk = 1'b0;

  always @(negedge clk) begin
    int d;
    if (!ss_n && p_ssn) begin
      trans = 0; cap = 0;
    end
    if (!ss_n && sclk !== p_sclk && !p_ssn) begin
      if ((trans % 2) == int'(b_cpha)) cap = (cap << 1) | int'(mosi);
      trans++;
    end
    d = b_cpha ? ((trans > 0) ? (trans - 1) / 2 : 0) : trans / 2;
    if (d >= b_n) d = b_n - 1;
    miso = b_lb ? !mosi : b_slv[b_n - 1 - d];
    p_ssn = ss_n; p_sclk = sclk;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic setup(input int len, input bit cpol, input bit cpha,
                       input int pre, input int rate, input bit lb,
                       input logic [15:0] slv);
    cfg_len_m1 = 4'(len); cfg_cpol = cpol; cfg_cpha = cpha;
    cfg_prescale = 8'(pre); cfg_rate = 8'(rate); cfg_loopback = lb;
    b_n = len_of(len); b_cpha = cpha; b_lb = lb; b_slv = slv;
    repeat (3) step();
  endtask

  task automatic offer(input logic [15:0] w);
    int t;
    tx_data = w; tx_valid = 1'b1;
    t = 0;
    step();
    while (!busy && t < 20) begin step(); t++; end
    tx_valid = 1'b0;
  endtask

  task automatic wait_rxv();
    int t;
    t = 0;
    while (!rx_valid && t < 5000) begin step(); t++; end
  endtask

  task automatic run_frame(input int len, input bit cpol, input bit cpha,
                           input int pre, input int rate, input bit lb,
                           input logic [15:0] txw, input logic [15:0] slv,
                           input string req);
    int n, h, t, mask;
    logic s0;
    setup(len, cpol, cpha, pre, rate, lb, slv);
    n = len_of(len);
    h = half_of(pre, rate);
    mask = (1 << n) - 1;
    offer(txw);
    // R2 first and second transition spacing
    t = 0; s0 = sclk;
    while (sclk == s0 && t < 5000) begin step(); t++; end
    chk(t == h, "R2", "first transition delay", t, h);
    t = 0; s0 = sclk;
    while (sclk == s0 && t < 5000) begin step(); t++; end
    chk(t == h, "R2", "half period", t, h);
    wait_rxv();
    chk(rx_valid == 1'b1, "R8", "rx_valid seen", int'(rx_valid), 1);
    chk(int'(rx_data) == (lb ? (int'(txw) & mask) : (int'(slv) & mask)), req,
        "rx_data", int'(rx_data), lb ? (int'(txw) & mask) : (int'(slv) & mask));
    chk((int'(rx_data) & ~mask) == 0, "R8", "upper rx bits", int'(rx_data) & ~mask, 0);
    chk(cap == (int'(txw) & mask), "R6", "mosi word", cap, int'(txw) & mask);
    chk(trans == 2 * n, "R1", "transition count", trans, 2 * n);
  endtask

  initial begin
    int k;
    step();
    // R11 reset state
    chk(ss_n == 1'b1, "R11", "ss_n", int'(ss_n), 1);
    chk(sclk == 1'b0, "R11", "sclk", int'(sclk), 0);
    chk(busy == 1'b0, "R11", "busy", int'(busy), 0);
    chk(rx_valid == 1'b0, "R11", "rx_valid", int'(rx_valid), 0);
    chk(rx_data == 16'h0, "R11", "rx_data", int'(rx_data), 0);
    chk(mosi == 1'b0, "R11", "mosi", int'(mosi), 0);
    step();
    rst = 1'b0;
    cfg_enable = 1'b1;
    step();

    // R4 idle level follows polarity
    cfg_cpol = 1'b1; step(); step();
    chk(sclk == 1'b1, "R4", "idle high", int'(sclk), 1);
    cfg_cpol = 1'b0; step(); step();
    chk(sclk == 1'b0, "R4", "idle low", int'(sclk), 0);

    run_frame(7, 0, 0, 2, 0, 0, 16'h00A5, 16'h003C, "R5");
    run_frame(15, 1, 1, 4, 2, 0, 16'hBEEF, 16'h1234, "R5");
    run_frame(3, 0, 1, 3, 1, 0, 16'hFFFB, 16'h0006, "R3");
    run_frame(0, 1, 0, 1, 0, 0, 16'h0009, 16'h000A, "R1");
    run_frame(11, 0, 0, 6, 0, 1, 16'h0ABC, 16'h0F0F, "R7");
    run_frame(12, 1, 1, 0, 3, 0, 16'h1555, 16'hFFFF, "R8");

    // R9 back-to-back: tx_valid held across the frame boundary
    setup(9, 0, 1, 2, 1, 1, 16'h0000);
    offer(16'h02AA);
    tx_data = 16'h0155; tx_valid = 1'b1;
    wait_rxv();
    chk(int'(rx_data) == 16'h02AA, "R7", "first b2b word", int'(rx_data), 16'h02AA);
    step();
    chk(busy == 1'b1, "R9", "restart after rx_valid", int'(busy), 1);
    tx_valid = 1'b0;
    wait_rxv();
    chk(int'(rx_data) == 16'h0155, "R7", "second b2b word", int'(rx_data), 16'h0155);

    // R10 abort mid-frame
    setup(7, 1, 0, 4, 0, 0, 16'h00FF);
    offer(16'h0081);
    repeat (9) step();
    cfg_enable = 1'b0;
    step();
    chk(ss_n == 1'b1, "R10", "ss_n after abort", int'(ss_n), 1);
    chk(busy == 1'b0, "R10", "busy after abort", int'(busy), 0);
    chk(sclk == 1'b1, "R10", "sclk after abort", int'(sclk), 1);
    chk(rx_valid == 1'b0, "R10", "no rx_valid", int'(rx_valid), 0);
    cfg_enable = 1'b1;
    step();
    chk(rx_valid == 1'b0, "R10", "no late rx_valid", int'(rx_valid), 0);

    // R10 abort on the closing tick
    setup(3, 0, 0, 4, 1, 0, 16'h0005);
    offer(16'h000C);
    k = half_of(4, 1) * (2 * 4 + 1) - 1;
    repeat (k) step();
    chk(ss_n == 1'b0 && busy == 1'b1, "R10", "frame still open",
        int'({ss_n, busy}), 1);
    cfg_enable = 1'b0;
    step();
    chk(rx_valid == 1'b0, "R10", "abort beats close", int'(rx_valid), 0);
    chk(ss_n == 1'b1, "R10", "ss_n on collision", int'(ss_n), 1);
    cfg_enable = 1'b1;
    step();

    // recovery frame after aborts
    run_frame(5, 0, 0, 2, 2, 0, 16'h002D, 16'h0033, "R5");

    repeat (4) step();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule